// File: doc/BRIEF.md
# Two-Level Local-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Each branch owns a short record of its own recent outcomes. The record sits in a small first-level table that is selected by low PC bits. That record is combined by XOR with a wider slice of the PC to pick one 2-bit saturating counter in a larger second-level table. The upper bit of the selected counter is the prediction.

The fetch side presents a PC on the prediction port and reads back a taken/not-taken bit in the same cycle. There is no register on this path. When the branch resolves, the execute side presents the same PC and the real outcome on the update port. On the next clock edge the selected counter moves one step toward the outcome, and the outcome is shifted into that branch's history record. Defaults: 64 history records of 10 bits each, and 1024 counters.

Top module: `lhp_predictor`

## Requirements
- R1: After reset every history record is all zeros and every counter holds 01 (weakly not taken), so every PC predicts not taken. A single taken update moves the counter it trains to 10.
- R2: The prediction is taken exactly when the selected counter holds 10 or 11.
- R3: A taken update adds one to the selected counter, but a counter already at 11 stays at 11.
- R4: A not-taken update subtracts one from the selected counter, but a counter already at 00 stays at 00.
- R5: PC bits [7:2] select the history record. On update, the outcome (1 = taken) enters bit 0 of that record, the older bits move up one place, and bit 9 is dropped.
- R6: The counter index is the 10-bit history record XOR PC bits [11:2]. History bit k pairs with PC bit k+2.
- R7: An update trains the counter selected by the history as it was before that same update shifts in the new outcome.
- R8: PC bits [1:0] and all PC bits above bit 11 have no effect on either port.
- R9: While upd_valid_i is low, no history record and no counter changes.
- R10: The prediction follows pred_pc_i combinationally. An update becomes visible on the prediction port only after the clock edge that samples it, so a same-cycle prediction of that PC still shows the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_pc_i | input | 32 | PC of the branch to be predicted |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| upd_valid_i | input | 1 | Update strobe for a resolved branch |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
The hardest case to reach is a counter that sits at a saturation limit while being selected again. The counter index moves every time the history shifts, so repeating one PC does not keep hitting the same counter. A run of the same outcome on one PC only settles once ten identical outcomes have filled its history. The stimulus therefore repeats a direction more than a dozen times in a row, then reverses it once, and checks that the counter stepped by exactly one. A long pseudo-random run then reuses a small set of branches whose indexes collide in both tables. Every prediction is compared against an arithmetic model held in the bench.

// File: rtl/lhp_pkg.sv
package lhp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;
  localparam ctr_t CTR_MAX     = 2'b11;
  localparam ctr_t CTR_MIN     = 2'b00;

  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    ctr_t n;
    if (taken) n = (c == CTR_MAX) ? c : c + 2'd1;
    else       n = (c == CTR_MIN) ? c : c - 2'd1;
    return n;
  endfunction

  function automatic logic ctr_is_taken(ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/lhp_hist_table.sv
module lhp_hist_table #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned HIST_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_bit_i,
  output logic [HIST_W-1:0] wr_hist_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];

  assign rd_hist_o = hist_q[rd_idx_i];
  // pre-shift value, used to index the counter being trained
  assign wr_hist_o = hist_q[wr_idx_i];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hist_q[g] <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        hist_q[g] <= {hist_q[g][HIST_W-2:0], wr_bit_i};
      end
    end
  end
endmodule

// File: rtl/lhp_ctr_table.sv
module lhp_ctr_table
  import lhp_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_taken_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_taken_i,
  output ctr_t             upd_ctr_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  ctr_t ctr_q [DEPTH];
  ctr_t ctr_nxt;

  assign rd_taken_o = ctr_is_taken(ctr_q[rd_idx_i]);
  assign upd_ctr_o  = ctr_q[upd_idx_i];
  assign ctr_nxt    = ctr_step(upd_ctr_o, upd_taken_i);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ctr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctr_q[g] <= CTR_WEAK_NT;
      end else if (upd_en_i && (upd_idx_i == IDX_W'(g))) begin
        ctr_q[g] <= ctr_nxt;
      end
    end
  end
endmodule

// File: rtl/lhp_predictor.sv
module lhp_predictor
  import lhp_pkg::*;
#(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned OFS_W    = 2,
  parameter int unsigned L1_IDX_W = 6,
  parameter int unsigned HIST_W   = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  localparam int unsigned L2_IDX_W = HIST_W;
  localparam int unsigned PC_TOP   = OFS_W + L2_IDX_W;

  logic [L1_IDX_W-1:0] pred_l1_idx, upd_l1_idx;
  logic [HIST_W-1:0]   pred_hist, upd_hist;
  logic [L2_IDX_W-1:0] pred_idx, upd_idx;
  ctr_t                upd_ctr;

  assign pred_l1_idx = pred_pc_i[OFS_W +: L1_IDX_W];
  assign upd_l1_idx  = upd_pc_i[OFS_W +: L1_IDX_W];

  lhp_hist_table #(
    .IDX_W (L1_IDX_W),
    .HIST_W(HIST_W)
  ) u_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (pred_l1_idx),
    .rd_hist_o(pred_hist),
    .wr_en_i  (upd_valid_i),
    .wr_idx_i (upd_l1_idx),
    .wr_bit_i (upd_taken_i),
    .wr_hist_o(upd_hist)
  );

  assign pred_idx = pred_hist ^ pred_pc_i[OFS_W +: L2_IDX_W];
  assign upd_idx  = upd_hist  ^ upd_pc_i[OFS_W +: L2_IDX_W];

  lhp_ctr_table #(
    .IDX_W(L2_IDX_W)
  ) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (pred_idx),
    .rd_taken_o (pred_taken_o),
    .upd_en_i   (upd_valid_i),
    .upd_idx_i  (upd_idx),
    .upd_taken_i(upd_taken_i),
    .upd_ctr_o  (upd_ctr)
  );

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc_i[OFS_W-1:0], upd_pc_i[OFS_W-1:0],
                            pred_pc_i[PC_W-1:PC_TOP], upd_pc_i[PC_W-1:PC_TOP]};
endmodule

// File: rtl/lhp_predictor_chk.sv
module lhp_predictor_chk
  import lhp_pkg::*;
#(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned OFS_W    = 2,
  parameter int unsigned L1_IDX_W = 6,
  parameter int unsigned HIST_W   = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PC_W-1:0]   pred_pc_i,
  input logic              pred_taken_o,
  input logic              upd_valid_i,
  input logic [PC_W-1:0]   upd_pc_i,
  input logic              upd_taken_i,
  input logic [HIST_W-1:0] upd_hist_i,
  input logic [HIST_W-1:0] upd_idx_i,
  input ctr_t              upd_ctr_i
);
  // R9: idle update port and steady PC keep the prediction steady
  a_r9_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> (!$stable(pred_pc_i) || $stable(pred_taken_o)));

  // R3: back-to-back taken on a saturated counter
  a_r3_sat_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && upd_ctr_i == CTR_MAX) ##1
    (upd_valid_i && upd_idx_i == $past(upd_idx_i)) |-> upd_ctr_i == CTR_MAX);

  // R4: back-to-back not-taken on an empty counter
  a_r4_sat_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i && upd_ctr_i == CTR_MIN) ##1
    (upd_valid_i && upd_idx_i == $past(upd_idx_i)) |-> upd_ctr_i == CTR_MIN);

  // R3: unsaturated counter steps up by exactly one
  a_r3_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && upd_ctr_i != CTR_MAX) ##1
    (upd_valid_i && upd_idx_i == $past(upd_idx_i)) |-> upd_ctr_i == 2'($past(upd_ctr_i) + 2'd1));

  // R5: outcome enters at bit 0 of the same record
  a_r5_hist_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i ##1
    (upd_valid_i && upd_pc_i[OFS_W +: L1_IDX_W] == $past(upd_pc_i[OFS_W +: L1_IDX_W])) |->
    upd_hist_i == {$past(upd_hist_i[HIST_W-2:0]), $past(upd_taken_i)});
endmodule

bind lhp_predictor lhp_predictor_chk #(
  .PC_W(PC_W), .OFS_W(OFS_W), .L1_IDX_W(L1_IDX_W), .HIST_W(HIST_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pred_pc_i   (pred_pc_i),
  .pred_taken_o(pred_taken_o),
  .upd_valid_i (upd_valid_i),
  .upd_pc_i    (upd_pc_i),
  .upd_taken_i (upd_taken_i),
  .upd_hist_i  (upd_hist),
  .upd_idx_i   (upd_idx),
  .upd_ctr_i   (upd_ctr)
);

// File: tb/lhp_predictor_tb.sv
module lhp_predictor_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pred_pc_i = '0;
  logic        pred_taken_o;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_taken_i = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] rng = 32'h1234_5678;

  // Arithmetic model built from the requirements
  bit [9:0] m_hist [64];
  bit [1:0] m_ctr  [1024];

  always #4 clk_i = ~clk_i;

  lhp_predictor u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pred_pc_i(pred_pc_i), .pred_taken_o(pred_taken_o),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_taken_i(upd_taken_i)
  );

  function automatic bit [9:0] m_idx(logic [31:0] pc);
    return m_hist[pc[7:2]] ^ pc[11:2];
  endfunction

  function automatic bit m_pred(logic [31:0] pc);
    return m_ctr[m_idx(pc)] >= 2;
  endfunction

  function automatic void m_update(logic [31:0] pc, bit t);
    bit [9:0] i;
    i = m_idx(pc);
    if (t && m_ctr[i] != 3) m_ctr[i] = m_ctr[i] + 1;
    if (!t && m_ctr[i] != 0) m_ctr[i] = m_ctr[i] - 1;
    m_hist[pc[7:2]] = {m_hist[pc[7:2]][8:0], t};
  endfunction

  function automatic logic [31:0] next_rnd();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  task automatic check(string tag, logic [31:0] pc, bit exp);
    total++;
    if (pred_taken_o !== exp) begin
      bad++;
      $display("FAIL %s pc=%h got=%0b exp=%0b", tag, pc, pred_taken_o, exp);
    end
  endtask

  task automatic probe(string tag, logic [31:0] pc);
    @(negedge clk_i);
    pred_pc_i = pc;
    #1 check(tag, pc, m_pred(pc));
  endtask

  // R10: same-cycle prediction shows pre-update state, then the new one
  task automatic update(string tag, logic [31:0] pc, bit t, bit valid);
    @(negedge clk_i);
    upd_valid_i = valid; upd_pc_i = pc; upd_taken_i = t; pred_pc_i = pc;
    #1 check({tag, "/R10-pre"}, pc, m_pred(pc));
    @(posedge clk_i);
    if (valid) m_update(pc, t);
    #1 upd_valid_i = 1'b0;
    upd_taken_i = ~t;
    #1 check({tag, "/R10-post"}, pc, m_pred(pc));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) m_hist[i] = '0;
    for (int i = 0; i < 1024; i++) m_ctr[i] = 2'b01;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1: all predictions not taken after reset
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk_i);
      pred_pc_i = {20'hABCDE, 10'(i), 2'b00};
      #1 check("R1-reset", pred_pc_i, 1'b0);
    end
    // R1/R2: one taken from weakly-not-taken crosses to taken
    update("R1", 32'h0000_0000, 1'b1, 1'b1);
    probe("R2", 32'h0000_0104);
    probe("R6", 32'h0000_0000);
    probe("R6", 32'h0000_0004);

    // R3/R5: fill history with ones, saturate, reverse once
    for (int k = 0; k < 15; k++) update("R3-sat", 32'h0000_0A50, 1'b1, 1'b1);
    update("R3-rev", 32'h0000_0A50, 1'b0, 1'b1);
    update("R7", 32'h0000_0A50, 1'b1, 1'b1);
    probe("R5", 32'h0000_0A50);
    // R4: fill history with zeros, drain to 00, reverse once
    for (int k = 0; k < 15; k++) update("R4-sat", 32'h0000_0360, 1'b0, 1'b1);
    update("R4-rev", 32'h0000_0360, 1'b1, 1'b1);
    probe("R4", 32'h0000_0360);

    // R8: offset and upper PC bits ignored on both ports
    for (int k = 0; k < 4; k++) update("R8-upd", {20'(k * 7919), 10'h0A5, 2'(k)}, 1'b1, 1'b1);
    for (int k = 0; k < 64; k++) probe("R8", {20'(k * 31), 10'(k * 17), 2'(k)});

    // R9: invalid updates change nothing
    for (int k = 0; k < 40; k++) update("R9", next_rnd(), next_rnd() % 2 == 1, 1'b0);
    for (int i = 0; i < 1024; i++) probe("R9-sweep", {22'h0, 10'(i)} << 2);

    // R5/R6/R7: pseudo-random traffic over colliding branches
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      logic [31:0] pc;
      r = next_rnd();
      pc = {r[31:20], 8'h00, 10'((r[7:3] % 24) * 37), r[1:0]};
      update("R7-rnd", pc, r[9] | r[10], 1'b1);
      probe("R6-rnd", next_rnd() & 32'h0000_0FFC);
    end
    for (int i = 0; i < 1024; i++) probe("R5-final", {22'h0, 10'(i)} << 2);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule